// File: doc/BRIEF.md
# DMA Channel Register File and Interrupt Block

This block is the software-visible register file of a multi-channel DMA controller. It decodes a 4 KB window of 32-bit words and holds, for each channel, a source address, a destination address, a next-descriptor pointer, a control word and a configuration word. It also holds a global configuration word and a sync word. The channel count is a parameter, either 8 or 2.

A separate transfer engine reads every channel register through flat output buses. It reports completions and faults through per-channel set pulses, and it rewrites channel registers through a write-back port. The block keeps raw and masked terminal-count and error status. The masks are not separate registers: each channel's masks come from two bits of its own configuration word. The block supports write-one-to-clear and reports which channels are enabled. It returns eight identification bytes and drives one level-sensitive interrupt line.

The bus is a plain valid/write/address/data interface. A read returns its data one cycle after the request. Any access that the block does not decode raises a one-cycle error flag.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register, every status bit, the read data and the error flag are zero, and the interrupt line is low.
- R2: Channel n occupies byte offsets 0x100+32*n to 0x11F+32*n. Word 0 of that slot is the source address, word 1 the destination, word 2 the next-descriptor pointer, word 3 control and word 4 configuration. All five words are read/write.
- R3: The global configuration word at 0x030 and the sync word at 0x034 are read/write.
- R4: Reading 0x01C returns a bitmap in which bit n equals bit 0 of channel n's configuration word.
- R5: A set pulse on terminal-count (or error) bit n sets raw bit n on the next edge. Raw terminal-count status reads at 0x014 and raw error status at 0x018.
- R6: Masked terminal-count status (0x004) is raw terminal-count ANDed with bit 15 of each channel's configuration. Masked error status (0x00C) is raw error ANDed with bit 14. 0x000 returns the OR of the two masked values.
- R7: Writing 0x008 clears every raw terminal-count bit that is 1 in the written data. Writing 0x010 does the same for raw error bits.
- R8: When a set pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The interrupt output is high exactly when some masked terminal-count or masked error bit is set.
- R10: Reads of 0xFE0 to 0xFFC return one identification byte per word: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x81 when there are 2 channels.
- R11: The following are errors: a channel slot at or above the channel count, slot words 5 to 7, an undefined or wrong-direction global word (reads of 0x008 or 0x010, writes of status or identification words), and any other offset. An error read returns zero, an error write changes nothing, and the error flag is high for exactly the one cycle after the request.
- R12: Read data appears the cycle after a read request and holds until the next read.
- R13: The engine write-back port writes the selected word of the selected channel. It takes priority over a bus write to the same word in the same cycle.
- R14: The channel output buses carry each channel's current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle flag for an undecoded access |
| eng_tc_set | input | NUM_CH | Terminal-count set pulses |
| eng_err_set | input | NUM_CH | Error set pulses |
| eng_wr_valid | input | 1 | Engine write-back strobe |
| eng_wr_chan | input | CHW | Write-back channel index |
| eng_wr_word | input | 3 | Write-back word index (0 to 4) |
| eng_wr_data | input | 32 | Write-back data |
| ch_src_o | output | 32*NUM_CH | Source addresses, channel n in bits [32n+31:32n] |
| ch_dst_o | output | 32*NUM_CH | Destination addresses |
| ch_next_o | output | 32*NUM_CH | Next-descriptor pointers |
| ch_ctrl_o | output | 32*NUM_CH | Control words |
| ch_cfg_o | output | 32*NUM_CH | Configuration words |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets status bits on channels whose masks are both on and both off. A design that ignored the configuration mask bits, or masked the raw views, would return wrong values at the masked words or drive the interrupt line wrongly. It drives a clear and a set pulse into the same bit in the same edge: a design that let the clear win would lose the completion. Two instances, one with 8 channels and one with 2, are read at the same offsets. This exposes a channel-range check tied to the wrong count, or an identification byte that does not follow the variant. The bench also probes slot words beyond the five, writes to read-only status, and collides the engine with the bus on one register. These catch writes that leak through, error flags that last too long, and the wrong write-back priority.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] nxt;
    logic [31:0] ctrl;
    logic [31:0] cfg;
  } chan_regs_t;

  localparam logic [2:0] CW_SRC  = 3'd0;
  localparam logic [2:0] CW_DST  = 3'd1;
  localparam logic [2:0] CW_NXT  = 3'd2;
  localparam logic [2:0] CW_CTRL = 3'd3;
  localparam logic [2:0] CW_CFG  = 3'd4;

  localparam logic [3:0] GW_STAT    = 4'd0;
  localparam logic [3:0] GW_TC_MSK  = 4'd1;
  localparam logic [3:0] GW_TC_CLR  = 4'd2;
  localparam logic [3:0] GW_ER_MSK  = 4'd3;
  localparam logic [3:0] GW_ER_CLR  = 4'd4;
  localparam logic [3:0] GW_TC_RAW  = 4'd5;
  localparam logic [3:0] GW_ER_RAW  = 4'd6;
  localparam logic [3:0] GW_ENMAP   = 4'd7;
  localparam logic [3:0] GW_GCFG    = 4'd12;
  localparam logic [3:0] GW_SYNC    = 4'd13;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_ERM_BIT = 14;
  localparam int CFG_TCM_BIT = 15;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic chan_regs_t put_word(input chan_regs_t r, input logic [2:0] w,
                                          input logic [31:0] d);
    chan_regs_t o;
    o = r;
    case (w)
      CW_SRC:  o.src  = d;
      CW_DST:  o.dst  = d;
      CW_NXT:  o.nxt  = d;
      CW_CTRL: o.ctrl = d;
      CW_CFG:  o.cfg  = d;
      default: o = r;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode #(
  parameter int NUM_CH = 8,
  parameter int CHW    = 3
) (
  input  logic            valid,
  input  logic            write,
  input  logic [11:0]     addr,
  output logic            chan_sel,
  output logic [CHW-1:0]  chan_idx,
  output logic [2:0]      chan_word,
  output logic            glob_sel,
  output logic [3:0]      glob_word,
  output logic            id_sel,
  output logic [2:0]      id_idx,
  output logic            illegal
);
  import dma_rf_pkg::*;

  logic in_chan, in_glob, in_id, chan_ok, glob_ok, rd_ok, wr_ok;

  always_comb begin
    in_chan   = (addr[11:8] == 4'h1);
    in_glob   = (addr[11:6] == 6'd0);
    in_id     = (addr[11:5] == 7'h7F);
    glob_word = addr[5:2];
    chan_word = addr[4:2];
    chan_idx  = addr[5+CHW-1:5];
    id_idx    = addr[4:2];
    chan_ok   = in_chan && ({1'b0, addr[7:5]} < 4'(NUM_CH)) && (addr[4:2] <= CW_CFG);
    rd_ok = (glob_word == GW_STAT)   || (glob_word == GW_TC_MSK) ||
            (glob_word == GW_ER_MSK) || (glob_word == GW_TC_RAW) ||
            (glob_word == GW_ER_RAW) || (glob_word == GW_ENMAP)  ||
            (glob_word == GW_GCFG)   || (glob_word == GW_SYNC);
    wr_ok = (glob_word == GW_TC_CLR) || (glob_word == GW_ER_CLR) ||
            (glob_word == GW_GCFG)   || (glob_word == GW_SYNC);
    glob_ok   = in_glob && (write ? wr_ok : rd_ok);
    chan_sel  = valid && chan_ok;
    glob_sel  = valid && glob_ok;
    id_sel    = valid && in_id && !write;
    illegal   = valid && !(chan_ok || glob_ok || (in_id && !write));
  end

endmodule

// File: rtl/dma_rf_channel.sv
module dma_rf_channel (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [2:0]             bus_word,
  input  logic [31:0]            bus_wdata,
  input  logic                   eng_we,
  input  logic [2:0]             eng_word,
  input  logic [31:0]            eng_wdata,
  output dma_rf_pkg::chan_regs_t regs_q
);
  import dma_rf_pkg::*;

  chan_regs_t regs_d;
  logic       regs_en;

  always_comb begin
    regs_en = bus_we || eng_we;
    regs_d  = regs_q;
    if (bus_we) regs_d = put_word(regs_d, bus_word, bus_wdata);
    if (eng_we) regs_d = put_word(regs_d, eng_word, eng_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       regs_q <= '0;
    else if (regs_en) regs_q <= regs_d;
  end

  // R11 / R13: registers move only on a decoded bus write or an engine write
  a_r11_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we || eng_we) |=> $stable(regs_q));

endmodule

// File: rtl/dma_rf_irq.sv
module dma_rf_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] er_set,
  input  logic              tc_clr_en,
  input  logic              er_clr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] er_mask,
  output logic [NUM_CH-1:0] tc_raw,
  output logic [NUM_CH-1:0] er_raw,
  output logic              irq_o
);

  logic [NUM_CH-1:0] tc_clr, er_clr, tc_d, er_d;

  always_comb begin
    tc_clr = tc_clr_en ? clr_bits : '0;
    er_clr = er_clr_en ? clr_bits : '0;
    tc_d   = (tc_raw & ~tc_clr) | tc_set;
    er_d   = (er_raw & ~er_clr) | er_set;
    irq_o  = |((tc_raw & tc_mask) | (er_raw & er_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_raw <= '0;
      er_raw <= '0;
    end else begin
      tc_raw <= tc_d;
      er_raw <= er_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      a_r5_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set[i] |=> tc_raw[i]);
      a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr[i] && !tc_set[i]) |=> !tc_raw[i]);
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (er_clr[i] && er_set[i]) |=> er_raw[i]);
    end
  endgenerate

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_raw == '0 && er_raw == '0) |-> !irq_o);

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NUM_CH = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  input  logic [NUM_CH-1:0]    eng_tc_set,
  input  logic [NUM_CH-1:0]    eng_err_set,
  input  logic                 eng_wr_valid,
  input  logic [CHW-1:0]       eng_wr_chan,
  input  logic [2:0]           eng_wr_word,
  input  logic [31:0]          eng_wr_data,
  output logic [32*NUM_CH-1:0] ch_src_o,
  output logic [32*NUM_CH-1:0] ch_dst_o,
  output logic [32*NUM_CH-1:0] ch_next_o,
  output logic [32*NUM_CH-1:0] ch_ctrl_o,
  output logic [32*NUM_CH-1:0] ch_cfg_o,
  output logic                 irq
);
  import dma_rf_pkg::*;

  localparam int PAD = 32 - NUM_CH;

  logic           chan_sel, glob_sel, id_sel, dec_illegal;
  logic [CHW-1:0] chan_idx;
  logic [2:0]     chan_word, id_idx;
  logic [3:0]     glob_word;

  chan_regs_t        regs [NUM_CH];
  logic [NUM_CH-1:0] tc_mask, er_mask, en_map, tc_raw, er_raw;
  logic [31:0]       gcfg_q, sync_q, rd_val, rdata_q;
  logic              err_q, gcfg_we, sync_we, rd_en;

  dma_rf_decode #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .chan_sel(chan_sel), .chan_idx(chan_idx), .chan_word(chan_word),
    .glob_sel(glob_sel), .glob_word(glob_word),
    .id_sel(id_sel), .id_idx(id_idx), .illegal(dec_illegal)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic bus_we_i, eng_we_i;
      assign bus_we_i = chan_sel && bus_write && (chan_idx == CHW'(i));
      assign eng_we_i = eng_wr_valid && (eng_wr_chan == CHW'(i)) && (eng_wr_word <= CW_CFG);
      dma_rf_channel u_ch (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we_i), .bus_word(chan_word), .bus_wdata(bus_wdata),
        .eng_we(eng_we_i), .eng_word(eng_wr_word), .eng_wdata(eng_wr_data),
        .regs_q(regs[i])
      );
      assign tc_mask[i] = regs[i].cfg[CFG_TCM_BIT];
      assign er_mask[i] = regs[i].cfg[CFG_ERM_BIT];
      assign en_map[i]  = regs[i].cfg[CFG_EN_BIT];
      assign ch_src_o [32*i +: 32] = regs[i].src;
      assign ch_dst_o [32*i +: 32] = regs[i].dst;
      assign ch_next_o[32*i +: 32] = regs[i].nxt;
      assign ch_ctrl_o[32*i +: 32] = regs[i].ctrl;
      assign ch_cfg_o [32*i +: 32] = regs[i].cfg;
    end
  endgenerate

  dma_rf_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tc_set(eng_tc_set), .er_set(eng_err_set),
    .tc_clr_en(glob_sel && bus_write && (glob_word == GW_TC_CLR)),
    .er_clr_en(glob_sel && bus_write && (glob_word == GW_ER_CLR)),
    .clr_bits(bus_wdata[NUM_CH-1:0]),
    .tc_mask(tc_mask), .er_mask(er_mask),
    .tc_raw(tc_raw), .er_raw(er_raw), .irq_o(irq)
  );

  always_comb begin
    gcfg_we = glob_sel && bus_write && (glob_word == GW_GCFG);
    sync_we = glob_sel && bus_write && (glob_word == GW_SYNC);
    rd_en   = bus_valid && !bus_write;
    rd_val  = '0;
    if (chan_sel) begin
      case (chan_word)
        CW_SRC:  rd_val = regs[chan_idx].src;
        CW_DST:  rd_val = regs[chan_idx].dst;
        CW_NXT:  rd_val = regs[chan_idx].nxt;
        CW_CTRL: rd_val = regs[chan_idx].ctrl;
        default: rd_val = regs[chan_idx].cfg;
      endcase
    end else if (glob_sel) begin
      case (glob_word)
        GW_STAT:   rd_val = {{PAD{1'b0}}, (tc_raw & tc_mask) | (er_raw & er_mask)};
        GW_TC_MSK: rd_val = {{PAD{1'b0}}, tc_raw & tc_mask};
        GW_ER_MSK: rd_val = {{PAD{1'b0}}, er_raw & er_mask};
        GW_TC_RAW: rd_val = {{PAD{1'b0}}, tc_raw};
        GW_ER_RAW: rd_val = {{PAD{1'b0}}, er_raw};
        GW_ENMAP:  rd_val = {{PAD{1'b0}}, en_map};
        GW_GCFG:   rd_val = gcfg_q;
        GW_SYNC:   rd_val = sync_q;
        default:   rd_val = '0;
      endcase
    end else if (id_sel) begin
      rd_val = {24'd0, id_byte(id_idx, NUM_CH)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q  <= '0;
      sync_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (gcfg_we) gcfg_q  <= bus_wdata;
      if (sync_we) sync_q  <= bus_wdata;
      if (rd_en)   rdata_q <= dec_illegal ? 32'd0 : rd_val;
      err_q <= dec_illegal;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R11: a bad access raises the flag on the following cycle, and only then
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |=> bus_err);
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_valid));
  // R12: read data moves only after a read request
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  tc_set = '0, er_set = '0;
  logic        ewv = 1'b0;
  logic [2:0]  ewc = '0, eww = '0;
  logic [31:0] ewd = '0;

  logic [31:0]  rdata, rdata2;
  logic         err, err2, irq, irq2;
  logic [255:0] src_o, dst_o, nxt_o, ctl_o, cfg_o;
  logic [63:0]  s2, d2, n2, c2, f2;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] rv, rv2;
  logic        re, re2;

  always #10 clk = ~clk;

  dma_regfile #(.NUM_CH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .bus_err(err),
    .eng_tc_set(tc_set), .eng_err_set(er_set), .eng_wr_valid(ewv),
    .eng_wr_chan(ewc), .eng_wr_word(eww), .eng_wr_data(ewd),
    .ch_src_o(src_o), .ch_dst_o(dst_o), .ch_next_o(nxt_o), .ch_ctrl_o(ctl_o),
    .ch_cfg_o(cfg_o), .irq(irq)
  );

  dma_regfile #(.NUM_CH(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2), .bus_err(err2),
    .eng_tc_set(2'b00), .eng_err_set(2'b00), .eng_wr_valid(1'b0),
    .eng_wr_chan(1'b0), .eng_wr_word(3'd0), .eng_wr_data(32'd0),
    .ch_src_o(s2), .ch_dst_o(d2), .ch_next_o(n2), .ch_ctrl_o(c2),
    .ch_cfg_o(f2), .irq(irq2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    rv = rdata; re = err; rv2 = rdata2; re2 = err2;
  endtask

  function automatic logic [7:0] exp_id(input int i, input int nch);
    case (i)
      0: exp_id = (nch == 8) ? 8'h80 : 8'h81;
      1: exp_id = 8'h10;
      2: exp_id = 8'h04;
      3: exp_id = 8'h0A;
      4: exp_id = 8'h0D;
      5: exp_id = 8'hF0;
      6: exp_id = 8'h05;
      default: exp_id = 8'hB1;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    rd(12'h000); chk("R1 status", rv, 0);
    rd(12'h030); chk("R1 gcfg", rv, 0);
    rd(12'h160); chk("R1 ch3 src", rv, 0);
  endtask

  task automatic t_chan_rw;
    wr(12'h160, 32'h1111_0003); wr(12'h164, 32'h2222_0003);
    wr(12'h168, 32'h3333_0003); wr(12'h16C, 32'h4444_0003);
    wr(12'h170, 32'h0000_C000);
    rd(12'h160); chk("R2 src", rv, 32'h1111_0003);
    rd(12'h164); chk("R2 dst", rv, 32'h2222_0003);
    rd(12'h168); chk("R2 next", rv, 32'h3333_0003);
    rd(12'h16C); chk("R2 ctrl", rv, 32'h4444_0003);
    rd(12'h170); chk("R2 cfg", rv, 32'h0000_C000);
    chk("R14 src out", src_o[96 +: 32], 32'h1111_0003);
    chk("R14 ctrl out", ctl_o[96 +: 32], 32'h4444_0003);
    wr(12'h1E0, 32'hABCD_0007); rd(12'h1E0); chk("R2 ch7 src", rv, 32'hABCD_0007);
  endtask

  task automatic t_glob;
    wr(12'h030, 32'h0000_0001); wr(12'h034, 32'h0000_A5A5);
    rd(12'h030); chk("R3 gcfg", rv, 32'h1);
    rd(12'h034); chk("R3 sync", rv, 32'hA5A5);
  endtask

  task automatic t_enable;
    wr(12'h110, 32'h1); wr(12'h1B0, 32'h1);
    rd(12'h01C); chk("R4 enmap", rv, 32'h21);
  endtask

  task automatic t_status;
    @(negedge clk); tc_set = 8'h09; er_set = 8'h28;
    @(negedge clk); tc_set = 8'h00; er_set = 8'h00;
    chk("R9 irq masked", {31'd0, irq}, 32'd1);
    rd(12'h014); chk("R5 raw tc", rv, 32'h09);
    rd(12'h018); chk("R5 raw err", rv, 32'h28);
    rd(12'h004); chk("R6 masked tc", rv, 32'h08);
    rd(12'h00C); chk("R6 masked err", rv, 32'h08);
    rd(12'h000); chk("R6 combined", rv, 32'h08);
    wr(12'h008, 32'h08);
    rd(12'h014); chk("R7 tc clear", rv, 32'h01);
    chk("R9 irq from err", {31'd0, irq}, 32'd1);
    wr(12'h010, 32'h08);
    rd(12'h018); chk("R7 err clear", rv, 32'h20);
    chk("R9 irq unmasked only", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_setwins;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h03;
    tc_set = 8'h02;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tc_set = 8'h00;
    rd(12'h014); chk("R8 set wins", rv, 32'h02);
  endtask

  task automatic t_id;
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i));
      chk("R10 id 8ch", rv, {24'd0, exp_id(i, 8)});
      chk("R10 id 2ch", rv2, {24'd0, exp_id(i, 2)});
    end
  endtask

  task automatic t_errors;
    rd(12'h114); chk("R11 slot word5 err", {31'd0, re}, 1); chk("R11 slot word5 zero", rv, 0);
    @(negedge clk); chk("R11 err one cycle", {31'd0, err}, 0);
    chk("R12 rdata held", rdata, 0);
    rd(12'h200); chk("R11 hole err", {31'd0, re}, 1);
    rd(12'h008); chk("R11 read clear word err", {31'd0, re}, 1);
    wr(12'h014, 32'hFF); rd(12'h014); chk("R11 raw not writable", rv, 32'h02);
    wr(12'h118, 32'hFFFF_FFFF); rd(12'h110); chk("R11 word6 write ignored", rv, 32'h1);
    wr(12'hFE0, 32'h55); rd(12'hFE0); chk("R11 id not writable", rv, 32'h80);
    rd(12'h140);
    chk("R11 ch2 ok on 8ch", {31'd0, re}, 0);
    chk("R11 ch2 err on 2ch", {31'd0, re2}, 1);
    chk("R11 ch2 zero on 2ch", rv2, 0);
  endtask

  task automatic t_engine;
    @(negedge clk); ewv = 1'b1; ewc = 3'd3; eww = 3'd0; ewd = 32'hDEAD_0000;
    @(negedge clk); ewv = 1'b0;
    rd(12'h160); chk("R13 engine write", rv, 32'hDEAD_0000);
    chk("R14 src out after wb", src_o[96 +: 32], 32'hDEAD_0000);
    @(negedge clk);
    ewv = 1'b1; ewc = 3'd3; eww = 3'd1; ewd = 32'hE000_0001;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h164; bus_wdata = 32'hB000_0002;
    @(negedge clk); ewv = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    rd(12'h164); chk("R13 engine beats bus", rv, 32'hE000_0001);
    chk("R14 dst out", dst_o[96 +: 32], 32'hE000_0001);
    wr(12'h16C, 32'h5); rd(12'h16C); chk("R12 read after write", rv, 32'h5);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_chan_rw;
    t_glob;
    t_enable;
    t_status;
    t_setwins;
    t_id;
    t_errors;
    t_engine;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

endmodule